// File: doc/BRIEF.md
# PCI Bridge Transaction Claim Filter

The block sits on both buses of a two-port PCI bridge. Port index 0 is the primary bus and every other index is a secondary bus. It watches each bus for the start of a transaction. On the edge where FRAME first asserts from idle, it captures the bus command and address bits [1:0]. It then decides whether the bridge acts as target for the transaction and whether the transaction crosses to the other side.

Each side has its own support table. The claim filter's verdict holds for the whole transaction. It also watches data phases and requests a disconnect when a claimed burst asks for an address order other than linear increment.

Address-window matching, DEVSEL timing, configuration space, data buffering and dual-address decoding belong to neighbouring blocks.

Top module: `pci_claim_filter`

## Requirements
- R1: A transaction starts on the first rising edge where `frame_ni` is sampled low while the port is idle. At that edge the command on `cbe_i` and `ad_lo_i` are captured. From the next cycle `claim_o`, `fwd_o` and `cls_o` reflect that capture, and later changes on `cbe_i`/`ad_lo_i` during the transaction have no effect on them.
- R2: `cls_o` encodes 0 idle, 1 interrupt acknowledge (0000), 2 special cycle (0001), 3 I/O (0010, 0011), 4 memory (0110, 0111, 1100, 1110, 1111), 5 configuration (1010, 1011), 6 reserved, 7 dual address cycle (1101).
- R3: The reserved codes 0100, 0101, 1000 and 1001 are never claimed or forwarded on any port.
- R4: Interrupt acknowledge and special cycle are never claimed or forwarded on any port.
- R5: I/O, memory and dual address cycle commands are claimed and forwarded on every port, whatever the value of `ad_lo_i`.
- R6: On the primary port, a configuration command is always claimed. It is forwarded only when the captured `ad_lo_i` is 01 (Type 1); with 00 (Type 0) it is claimed and not forwarded.
- R7: On a secondary port, a configuration command is claimed and forwarded only when the captured `ad_lo_i` is 01. Any other value gives neither.
- R8: A claimed non-configuration transaction with captured `ad_lo_i` not equal to 00 raises `stop_o`. It rises in the cycle after the first edge on which `irdy_ni` and `trdy_ni` are both sampled low, and it stays high while `frame_ni` remains low.
- R9: `stop_o` is never raised for a linear-order burst (`ad_lo_i` 00), a configuration command or an unclaimed transaction. Once raised, it drops in the cycle after `frame_ni` is sampled high.
- R10: When `frame_ni` and `irdy_ni` are both sampled high, all port outputs return to 0. The same holds while `rst_ni` is low.
- R11: Each port decides independently. Activity on one port does not change the outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_ni | input | NUM_PORTS | FRAME per port, active low |
| irdy_ni | input | NUM_PORTS | IRDY per port, active low |
| trdy_ni | input | NUM_PORTS | TRDY per port, active low |
| cbe_i | input | 4*NUM_PORTS | Command/byte enables per port |
| ad_lo_i | input | 2*NUM_PORTS | AD[1:0] per port |
| claim_o | output | NUM_PORTS | Bridge acts as target |
| fwd_o | output | NUM_PORTS | Transaction crosses the bridge |
| cls_o | output | 3*NUM_PORTS | Decoded command class |
| stop_o | output | NUM_PORTS | Disconnect request |

## Verification
The assertions assume each port follows PCI framing. FRAME rises only while IRDY is low or already high, and the bus passes through a sampled idle cycle (FRAME and IRDY both high) between transactions. The stop-related properties also assume TRDY is driven only while the transaction is active.

The bench drives every transaction through one task sequence. That sequence is address phase, data phases, final phase with FRAME high and IRDY low, then idle. All pins change on the falling clock edge, so the framing assumptions always hold.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  localparam int CMD_W   = 4;
  localparam int AD_LO_W = 2;
  localparam int CLS_W   = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_NONE = 3'd0,
    CLS_IACK = 3'd1,
    CLS_SPEC = 3'd2,
    CLS_IO   = 3'd3,
    CLS_MEM  = 3'd4,
    CLS_CFG  = 3'd5,
    CLS_RSVD = 3'd6,
    CLS_DAC  = 3'd7
  } cls_e;

  localparam logic [AD_LO_W-1:0] CFG_TYPE1 = 2'b01;
  localparam logic [AD_LO_W-1:0] BURST_LIN = 2'b00;
endpackage

// File: rtl/pcf_cmd_decode.sv
module pcf_cmd_decode
  import pcf_pkg::*;
#(
  parameter bit SECONDARY = 1'b0
) (
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic [AD_LO_W-1:0] ad_lo_i,
  output cls_e               cls_o,
  output logic               claim_o,
  output logic               fwd_o,
  output logic               cfg_o
);
  logic plain_ok;
  logic type1;

  always_comb begin
    unique case (cmd_i)
      4'b0000:                            cls_o = CLS_IACK;
      4'b0001:                            cls_o = CLS_SPEC;
      4'b0010, 4'b0011:                   cls_o = CLS_IO;
      4'b0110, 4'b0111, 4'b1100,
      4'b1110, 4'b1111:                   cls_o = CLS_MEM;
      4'b1010, 4'b1011:                   cls_o = CLS_CFG;
      4'b1101:                            cls_o = CLS_DAC;
      default:                            cls_o = CLS_RSVD;
    endcase
  end

  assign plain_ok = (cls_o == CLS_IO) || (cls_o == CLS_MEM) || (cls_o == CLS_DAC);
  assign cfg_o    = (cls_o == CLS_CFG);
  assign type1    = (ad_lo_i == CFG_TYPE1);

  // side-specific support table
  if (SECONDARY) begin : g_sec
    assign claim_o = plain_ok || (cfg_o && type1);
  end else begin : g_pri
    assign claim_o = plain_ok || cfg_o;
  end

  // type 0 config targets the bridge itself
  assign fwd_o = claim_o && !(cfg_o && !type1);
endmodule

// File: rtl/pcf_port_track.sv
module pcf_port_track
  import pcf_pkg::*;
#(
  parameter bit SECONDARY = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_ni,
  input  logic               irdy_ni,
  input  logic               trdy_ni,
  input  logic [CMD_W-1:0]   cbe_i,
  input  logic [AD_LO_W-1:0] ad_lo_i,
  output logic               claim_o,
  output logic               fwd_o,
  output logic [CLS_W-1:0]   cls_o,
  output logic               stop_o
);
  logic               active_q;
  logic [CMD_W-1:0]   cmd_q;
  logic [AD_LO_W-1:0] ad_q;
  logic               stop_q;
  cls_e               dec_cls;
  logic               dec_claim, dec_fwd, dec_cfg;
  logic               bus_idle, xfer, need_disc;

  pcf_cmd_decode #(.SECONDARY(SECONDARY)) u_dec (
    .cmd_i   (cmd_q),
    .ad_lo_i (ad_q),
    .cls_o   (dec_cls),
    .claim_o (dec_claim),
    .fwd_o   (dec_fwd),
    .cfg_o   (dec_cfg)
  );

  assign bus_idle  = frame_ni && irdy_ni;
  assign xfer      = active_q && !irdy_ni && !trdy_ni;
  assign need_disc = dec_claim && !dec_cfg && (ad_q != BURST_LIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cmd_q    <= '0;
      ad_q     <= '0;
      stop_q   <= 1'b0;
    end else if (bus_idle) begin
      active_q <= 1'b0;
      cmd_q    <= '0;
      ad_q     <= '0;
      stop_q   <= 1'b0;
    end else begin
      if (!active_q && !frame_ni) begin
        active_q <= 1'b1;
        cmd_q    <= cbe_i;
        ad_q     <= ad_lo_i;
      end
      if (frame_ni)
        stop_q <= 1'b0;
      else if (xfer && need_disc)
        stop_q <= 1'b1;
    end
  end

  assign claim_o = active_q && dec_claim;
  assign fwd_o   = active_q && dec_fwd;
  assign cls_o   = active_q ? dec_cls : CLS_NONE;
  assign stop_o  = stop_q;

  a_r8_stop_follows_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_q) |-> $past(!irdy_ni && !trdy_ni && !frame_ni));
  a_r9_stop_drops_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_ni) |-> !stop_q);
  a_r1_capture_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && $past(active_q)) |-> ($stable(cmd_q) && $stable(ad_q)));
endmodule

// File: rtl/pci_claim_filter.sv
module pci_claim_filter
  import pcf_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_PORTS-1:0]         frame_ni,
  input  logic [NUM_PORTS-1:0]         irdy_ni,
  input  logic [NUM_PORTS-1:0]         trdy_ni,
  input  logic [NUM_PORTS*CMD_W-1:0]   cbe_i,
  input  logic [NUM_PORTS*AD_LO_W-1:0] ad_lo_i,
  output logic [NUM_PORTS-1:0]         claim_o,
  output logic [NUM_PORTS-1:0]         fwd_o,
  output logic [NUM_PORTS*CLS_W-1:0]   cls_o,
  output logic [NUM_PORTS-1:0]         stop_o
);
  // port 0 is primary, the rest secondary (R11: one tracker each)
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [CLS_W-1:0] cls_p;

    pcf_port_track #(.SECONDARY(p != 0)) u_trk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .frame_ni (frame_ni[p]),
      .irdy_ni  (irdy_ni[p]),
      .trdy_ni  (trdy_ni[p]),
      .cbe_i    (cbe_i[p*CMD_W +: CMD_W]),
      .ad_lo_i  (ad_lo_i[p*AD_LO_W +: AD_LO_W]),
      .claim_o  (claim_o[p]),
      .fwd_o    (fwd_o[p]),
      .cls_o    (cls_p),
      .stop_o   (stop_o[p])
    );
    assign cls_o[p*CLS_W +: CLS_W] = cls_p;

    a_r3_r4_no_claim_unsupported: assert property (@(posedge clk_i) disable iff (!rst_ni)
      claim_o[p] |-> !(cls_p inside {CLS_RSVD, CLS_IACK, CLS_SPEC}));
    a_r6_fwd_needs_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fwd_o[p] |-> claim_o[p]);
    a_r9_stop_needs_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_o[p] |-> (claim_o[p] && cls_p != CLS_CFG));
    a_r10_idle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(frame_ni[p] && irdy_ni[p]) |->
        (!claim_o[p] && !fwd_o[p] && !stop_o[p] && cls_p == CLS_NONE));
  end
endmodule

// File: tb/sim_pci_claim_filter.sv
module sim_pci_claim_filter;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] frame_n, irdy_n, trdy_n;
  logic [NP*4-1:0] cbe;
  logic [NP*2-1:0] ad;
  logic [NP-1:0] claim, fwd, stop;
  logic [NP*3-1:0] cls;

  int n_chk = 0;
  int n_bad = 0;

  always #5ns clk = ~clk;

  pci_claim_filter #(.NUM_PORTS(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_ni(frame_n), .irdy_ni(irdy_n),
    .trdy_ni(trdy_n), .cbe_i(cbe), .ad_lo_i(ad), .claim_o(claim),
    .fwd_o(fwd), .cls_o(cls), .stop_o(stop)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int e_cls(input logic [3:0] c);
    case (c)
      4'b0000: return 1;
      4'b0001: return 2;
      4'b0010, 4'b0011: return 3;
      4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: return 4;
      4'b1010, 4'b1011: return 5;
      4'b1101: return 7;
      default: return 6;
    endcase
  endfunction

  function automatic bit e_claim(input int p, input logic [3:0] c, input logic [1:0] a);
    int k = e_cls(c);
    if (k == 3 || k == 4 || k == 7) return 1;
    if (k == 5) return (p == 0) ? 1'b1 : (a == 2'b01);
    return 0;
  endfunction

  function automatic bit e_fwd(input int p, input logic [3:0] c, input logic [1:0] a);
    if (!e_claim(p, c, a)) return 0;
    if (e_cls(c) == 5) return a == 2'b01;
    return 1;
  endfunction

  function automatic bit e_stop(input int p, input logic [3:0] c, input logic [1:0] a);
    return e_claim(p, c, a) && e_cls(c) != 5 && a != 2'b00;
  endfunction

  // address phase, then data-phase byte enables overwrite cbe (R1)
  task automatic start_txn(input int p, input logic [3:0] c, input logic [1:0] a);
    @(negedge clk);
    frame_n[p] = 1'b0;
    cbe[p*4 +: 4] = c;
    ad[p*2 +: 2] = a;
    @(negedge clk);
    cbe[p*4 +: 4] = 4'b0100;
    ad[p*2 +: 2] = ~a;
  endtask

  task automatic end_txn(input int p);
    irdy_n[p] = 1'b0;
    frame_n[p] = 1'b1;
    trdy_n[p] = 1'b0;
    @(negedge clk);
    irdy_n[p] = 1'b1;
    trdy_n[p] = 1'b1;
    @(negedge clk);
    chk(!claim[p] && !fwd[p] && !stop[p] && cls[p*3 +: 3] == 0, "R10",
        {claim[p], fwd[p], stop[p]}, 0);
  endtask

  task automatic t_reset();
    chk(claim == 0 && fwd == 0 && stop == 0 && cls == 0, "R10 reset", int'(claim), 0);
  endtask

  // R2 R3 R4 R5 R6 R7: full table on both ports
  task automatic t_table();
    for (int p = 0; p < NP; p++)
      for (int c = 0; c < 16; c++)
        for (int a = 0; a < 2; a++) begin
          start_txn(p, 4'(c), 2'(a));
          chk(int'(cls[p*3 +: 3]) == e_cls(4'(c)), "R2", cls[p*3 +: 3], e_cls(4'(c)));
          chk(claim[p] == e_claim(p, 4'(c), 2'(a)), "R3/R4/R5 R6 R7 claim",
              claim[p], e_claim(p, 4'(c), 2'(a)));
          chk(fwd[p] == e_fwd(p, 4'(c), 2'(a)), "R6 R7 fwd", fwd[p], e_fwd(p, 4'(c), 2'(a)));
          end_txn(p);
        end
  endtask

  // R8 R9: burst order and disconnect timing
  task automatic t_disc(input int p, input logic [3:0] c, input logic [1:0] a);
    bit es = e_stop(p, c, a);
    start_txn(p, c, a);
    chk(stop[p] == 1'b0, "R8 no stop before xfer", stop[p], 0);
    irdy_n[p] = 1'b0;
    trdy_n[p] = 1'b0;
    @(negedge clk);
    chk(stop[p] == es, "R8 R9 stop after first xfer", stop[p], es);
    trdy_n[p] = 1'b1;
    @(negedge clk);
    chk(stop[p] == es, "R8 stop held", stop[p], es);
    chk(claim[p] == e_claim(p, c, a), "R1 claim held", claim[p], e_claim(p, c, a));
    frame_n[p] = 1'b1;
    trdy_n[p] = 1'b0;
    @(negedge clk);
    chk(stop[p] == 1'b0, "R9 stop drops", stop[p], 0);
    irdy_n[p] = 1'b1;
    trdy_n[p] = 1'b1;
    @(negedge clk);
    chk(claim[p] == 0 && stop[p] == 0, "R10 idle", claim[p], 0);
  endtask

  // R11: port 1 idle while port 0 works; then both concurrently
  task automatic t_indep();
    start_txn(0, 4'b0111, 2'b10);
    chk(claim[1] == 0 && cls[5:3] == 0, "R11 other port quiet", claim[1], 0);
    @(negedge clk);
    frame_n[1] = 1'b0;
    cbe[7:4] = 4'b1010;
    ad[3:2] = 2'b00;
    @(negedge clk);
    chk(claim[1] == 0 && claim[0] == 1, "R11 sec cfg t0 vs pri mem",
        {claim[1], claim[0]}, 1);
    chk(cls[5:3] == 3'd5 && cls[2:0] == 3'd4, "R11 classes", cls, 8'h2c);
    end_txn(1);
    chk(claim[0] == 1, "R11 primary unaffected", claim[0], 1);
    end_txn(0);
  endtask

  initial begin
    #2ms;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    frame_n = '1; irdy_n = '1; trdy_n = '1;
    cbe = '0; ad = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_table();
    t_disc(0, 4'b0110, 2'b10);
    t_disc(1, 4'b0011, 2'b01);
    t_disc(0, 4'b1110, 2'b00);
    t_disc(1, 4'b1011, 2'b01);
    t_disc(0, 4'b1010, 2'b01);
    t_disc(1, 4'b0100, 2'b11);
    t_disc(0, 4'b0000, 2'b11);
    t_disc(1, 4'b1101, 2'b11);
    t_indep();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule